// File: doc/BRIEF.md
# Scrolling Character Display Memory

This block holds the character codes of a one-line character display. The store has 80 entries of 8 bits each, at addresses 0x00 to 0x4F. A host port writes and reads codes at the address held in an internal address counter. The counter steps forward after every access, so a string can be streamed in without reloading the address.

A refresh port asks for one visible digit at a time. For each request it returns the code stored at the digit number plus a circular window offset, taken modulo 80. Two commands move that offset by one in either direction, which scrolls the eight visible digits around the whole 80-entry ring. With no shift, digit 0 shows address 0x00 and digit 7 shows address 0x07. One shift right makes digit 0 show 0x4F.

The store has a single access path. Refresh reads always take it. A host access that arrives in a cycle with a refresh read is held in a one-entry buffer and carried out in the next cycle that has no refresh read. While the buffer is full, the block flags itself busy. A host access therefore never corrupts or delays a refresh result.

Top module: `char_window_ram`

## Requirements
- R1: Each entry stores an 8-bit code, and a write followed by a read of the same address returns that code unchanged.
- R2: The 7-bit address counter steps by one after every executed host write or read and goes from 0x4F to 0x00. A load command with value v sets it to v when v < 80 and to v - 80 when v is 80 or more.
- R3: A refresh request for digit d (0..7) is answered one cycle later with `ref_valid` high and `ref_code` equal to the code at address (offset + d) mod 80. The offset is the one in force in the cycle of the request.
- R4: The window offset starts at 0. `shift_left` alone adds one and goes from 79 to 0. `shift_right` alone subtracts one and goes from 0 to 79. Both together leave the offset unchanged.
- R5: A synchronous reset (`rst` high at a rising edge) clears the offset and the address counter to 0. It also drives `cpu_busy`, `cpu_rvalid` and `ref_valid` low.
- R6: When a host write or read meets a refresh request in the same cycle, the refresh read goes first. The host access is held, `cpu_busy` is high from the next cycle, and the access completes in the first later cycle with no refresh request. `cpu_busy` falls after that cycle.
- R7: While `cpu_busy` is high, new write, read and address-load commands have no effect.
- R8: A host read returns its code on `cpu_rdata` with `cpu_rvalid` high for one cycle. This happens one cycle after the read executes.
- R9: A host write changes only the addressed entry. Refresh results for every other address keep their earlier codes.
- R10: When write and read are asserted together, only the write is performed and no read result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Write `cpu_wdata` at the counter address |
| cpu_rd | input | 1 | Read the code at the counter address |
| cpu_wdata | input | 8 | Code to write |
| cpu_load | input | 1 | Load the address counter |
| cpu_load_addr | input | 7 | Value for the address counter |
| shift_left | input | 1 | Move the window offset up by one |
| shift_right | input | 1 | Move the window offset down by one |
| cpu_rdata | output | 8 | Read result |
| cpu_rvalid | output | 1 | `cpu_rdata` holds a new result |
| cpu_busy | output | 1 | A host access is waiting in the buffer |
| cur_addr | output | 7 | Present address counter value |
| ref_req | input | 1 | Refresh read request |
| ref_digit | input | 3 | Visible digit requested |
| ref_code | output | 8 | Code for the requested digit |
| ref_valid | output | 1 | `ref_code` holds a new result |

## Verification
The hardest situation to reach is a held host access that meets further refresh requests and new host commands while it waits. It must survive several refresh-only cycles, ignore the commands issued on top of it, and then complete at the unchanged counter address. The stimulus holds `ref_req` high for several cycles after a collision and issues writes, reads and address loads during that time. It then reads back to show that only the held access took effect. A long random phase mixes refresh requests on most cycles with shifts and host traffic, which exercises wraps of both the offset and the counter.

// File: rtl/char_window_ram.sv
module char_window_ram #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 7,
  parameter int RING   = 80,
  parameter int DIGITS = 8,
  parameter int DIG_W  = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CODE_W-1:0] cpu_wdata,
  input  logic              cpu_load,
  input  logic [ADDR_W-1:0] cpu_load_addr,
  input  logic              shift_left,
  input  logic              shift_right,
  output logic [CODE_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_busy,
  output logic [ADDR_W-1:0] cur_addr,
  input  logic              ref_req,
  input  logic [DIG_W-1:0]  ref_digit,
  output logic [CODE_W-1:0] ref_code,
  output logic              ref_valid
);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(RING - 1);
  localparam logic [ADDR_W:0]   RING_X = (ADDR_W+1)'(RING);

  logic [CODE_W-1:0] mem [0:RING-1];
  logic [ADDR_W-1:0] addr, ofs;
  logic              pend_v, pend_wr;
  logic [CODE_W-1:0] pend_data;

  logic              cmd, issue, do_cpu, op_wr;
  logic [CODE_W-1:0] op_data;
  logic [ADDR_W:0]   ref_sum;
  logic [ADDR_W-1:0] ref_addr, load_val, addr_next;

  assign cmd     = cpu_wr | cpu_rd;
  assign issue   = cmd & ~pend_v;
  assign do_cpu  = ~ref_req & (pend_v | issue);
  assign op_wr   = pend_v ? pend_wr : cpu_wr;
  assign op_data = pend_v ? pend_data : cpu_wdata;

  assign ref_sum  = {1'b0, ofs} + {{(ADDR_W+1-DIG_W){1'b0}}, ref_digit};
  assign ref_addr = (ref_sum >= RING_X) ? ADDR_W'(ref_sum - RING_X) : ref_sum[ADDR_W-1:0];

  assign load_val  = ({1'b0, cpu_load_addr} >= RING_X) ?
                     ADDR_W'({1'b0, cpu_load_addr} - RING_X) : cpu_load_addr;
  assign addr_next = (addr == LAST) ? '0 : addr + 1'b1;

  assign cur_addr = addr;
  assign cpu_busy = pend_v;

  always_ff @(posedge clk) begin
    if (do_cpu && op_wr) mem[addr] <= op_data;
    if (ref_req) ref_code <= mem[ref_addr];
    if (do_cpu && !op_wr) cpu_rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      ofs        <= '0;
      pend_v     <= 1'b0;
      pend_wr    <= 1'b0;
      pend_data  <= '0;
      cpu_rvalid <= 1'b0;
      ref_valid  <= 1'b0;
    end else begin
      ref_valid  <= ref_req;
      cpu_rvalid <= do_cpu & ~op_wr;

      if (do_cpu)
        addr <= addr_next;
      else if (cpu_load && !cmd && !pend_v)
        addr <= load_val;

      if (ref_req && issue) begin
        pend_v    <= 1'b1;
        pend_wr   <= cpu_wr;
        pend_data <= cpu_wdata;
      end else if (do_cpu) begin
        pend_v <= 1'b0;
      end

      if (shift_left && !shift_right)
        ofs <= (ofs == LAST) ? '0 : ofs + 1'b1;
      else if (shift_right && !shift_left)
        ofs <= (ofs == '0) ? LAST : ofs - 1'b1;
    end
  end
endmodule

// File: rtl/char_window_ram_chk.sv
module char_window_ram_chk #(
  parameter int ADDR_W = 7,
  parameter int RING   = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              ref_req,
  input logic              cpu_busy,
  input logic              cpu_rvalid,
  input logic              ref_valid,
  input logic              shift_left,
  input logic              shift_right,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] ofs
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(RING - 1);

  assert_addr_in_ring_R2: assert property (@(posedge clk) disable iff (rst)
    cur_addr <= LAST);

  assert_ofs_in_ring_R4: assert property (@(posedge clk) disable iff (rst)
    ofs <= LAST);

  assert_ofs_wrap_up_R4: assert property (@(posedge clk) disable iff (rst)
    shift_left && !shift_right && ofs == LAST |=> ofs == '0);

  assert_ofs_wrap_down_R4: assert property (@(posedge clk) disable iff (rst)
    shift_right && !shift_left && ofs == '0 |=> ofs == LAST);

  assert_ref_answer_R3: assert property (@(posedge clk) disable iff (rst)
    ref_req |=> ref_valid);

  assert_ref_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !ref_req |=> !ref_valid);

  assert_collision_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ref_req && (cpu_wr || cpu_rd) && !cpu_busy |=> cpu_busy);

  assert_hold_drains_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_busy && !ref_req |=> !cpu_busy);

  assert_no_read_under_refresh_R8: assert property (@(posedge clk) disable iff (rst)
    ref_req |=> !cpu_rvalid);

  assert_write_no_result_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && !cpu_busy && !ref_req |=> !cpu_rvalid);
endmodule

bind char_window_ram char_window_ram_chk #(.ADDR_W(ADDR_W), .RING(RING)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ref_req(ref_req),
  .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .ref_valid(ref_valid),
  .shift_left(shift_left), .shift_right(shift_right), .cur_addr(cur_addr), .ofs(ofs)
);

// File: tb/tb_char_window_ram.sv
`timescale 1ns/1ps
module tb_char_window_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 0, cpu_rd = 0, cpu_load = 0, shift_left = 0, shift_right = 0, ref_req = 0;
  logic [7:0] cpu_wdata = 0;
  logic [6:0] cpu_load_addr = 0;
  logic [2:0] ref_digit = 0;
  logic [7:0] cpu_rdata, ref_code;
  logic       cpu_rvalid, cpu_busy, ref_valid;
  logic [6:0] cur_addr;

  always #4 clk = ~clk;

  char_window_ram dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_load(cpu_load), .cpu_load_addr(cpu_load_addr), .shift_left(shift_left),
    .shift_right(shift_right), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .cpu_busy(cpu_busy), .cur_addr(cur_addr), .ref_req(ref_req), .ref_digit(ref_digit),
    .ref_code(ref_code), .ref_valid(ref_valid)
  );

  int checks = 0, errors = 0;
  logic [7:0] ref_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] m_mem [0:79];
  int m_ofs = 0, m_addr = 0;
  bit m_pend = 0, m_pwr = 0;
  logic [7:0] m_pdata = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ref_valid) begin
        if (ref_q.size() == 0) check(0, "R3 unexpected ref_valid", 1, 0);
        else begin
          logic [7:0] e;
          e = ref_q.pop_front();
          check(ref_code === e, "R3/R9 ref_code", ref_code, e);
        end
      end
      if (cpu_rvalid) begin
        if (rd_q.size() == 0) check(0, "R8/R10 unexpected cpu_rvalid", 1, 0);
        else begin
          logic [7:0] e;
          e = rd_q.pop_front();
          check(cpu_rdata === e, "R1/R8 cpu_rdata", cpu_rdata, e);
        end
      end
    end
  end

  task automatic step(input bit wr, input bit rd, input logic [7:0] wd, input bit ld,
                      input logic [6:0] la, input bit sl, input bit sr,
                      input bit rq, input logic [2:0] dg);
    bit issue, docpu, opwr;
    logic [7:0] opd;
    @(negedge clk);
    check(cur_addr === 7'(m_addr), "R2 cur_addr", cur_addr, m_addr);
    check(cpu_busy === m_pend, "R6/R7 cpu_busy", cpu_busy, m_pend);
    cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd; cpu_load = ld; cpu_load_addr = la;
    shift_left = sl; shift_right = sr; ref_req = rq; ref_digit = dg;
    if (rq) ref_q.push_back(m_mem[(m_ofs + dg) % 80]);
    issue = (wr || rd) && !m_pend;
    docpu = !rq && (m_pend || issue);
    opwr  = m_pend ? m_pwr : wr;
    opd   = m_pend ? m_pdata : wd;
    if (docpu) begin
      if (opwr) m_mem[m_addr] = opd;
      else rd_q.push_back(m_mem[m_addr]);
      m_addr = (m_addr + 1) % 80;
    end else if (ld && !m_pend && !wr && !rd) begin
      m_addr = (la >= 80) ? la - 80 : la;
    end
    if (rq && issue) begin m_pend = 1; m_pwr = wr; m_pdata = wd; end
    else if (docpu) m_pend = 0;
    if (sl && !sr) m_ofs = (m_ofs + 1) % 80;
    else if (sr && !sl) m_ofs = (m_ofs + 79) % 80;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0); endtask
  task automatic wr_code(input logic [7:0] d); step(1,0,d,0,0,0,0,0,0); endtask
  task automatic rd_code(); step(0,1,0,0,0,0,0,0,0); endtask
  task automatic load(input logic [6:0] a); step(0,0,0,1,a,0,0,0,0); endtask
  task automatic refresh(input logic [2:0] d); step(0,0,0,0,0,0,0,1,d); endtask
  task automatic shift(input bit l, input bit r); step(0,0,0,0,0,l,r,0,0); endtask
  task automatic refresh_all();
    for (int d = 0; d < 8; d++) refresh(3'(d));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cpu_wr = 0; cpu_rd = 0; cpu_load = 0; shift_left = 0; shift_right = 0; ref_req = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_ofs = 0; m_addr = 0; m_pend = 0;
    // R5: state cleared after reset
    check(cur_addr === 7'd0, "R5 cur_addr", cur_addr, 0);
    check(cpu_busy === 1'b0, "R5 cpu_busy", cpu_busy, 0);
    check(ref_valid === 1'b0, "R5 ref_valid", ref_valid, 0);
    check(cpu_rvalid === 1'b0, "R5 cpu_rvalid", cpu_rvalid, 0);
  endtask

  initial begin
    #(200000 * 8);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1/R2: fill all 80 entries; the counter wraps back to 0
    for (int i = 0; i < 80; i++) wr_code(8'(i + 8'h30));
    idle();
    check(cur_addr === 7'd0, "R2 wrap after 80 writes", cur_addr, 0);
    // R3: unshifted window shows 0x00..0x07
    refresh_all();
    // R4: one right shift -> digit 0 shows 0x4F
    shift(0, 1);
    refresh_all();
    // R4: two left shifts -> digit 0 shows 0x01, digit 7 shows 0x08
    shift(1, 0); shift(1, 0);
    refresh_all();
    // R4: both together hold the offset
    shift(1, 1);
    refresh(0);
    // R4: walk the full ring to the left, covering 79 -> 0
    for (int i = 0; i < 82; i++) begin step(0,0,0,0,0,1,0,1,3'(i)); end
    refresh_all();
    // R2/R8: read across the 0x4F -> 0x00 wrap
    load(7'h4E); rd_code(); rd_code(); rd_code(); idle();
    // R2: load above the ring is reduced by 80
    load(7'h55); idle();
    check(cur_addr === 7'h05, "R2 load 0x55", cur_addr, 5);
    // R6/R7: collide a write, keep refresh busy, try new commands
    load(7'h10);
    step(1,0,8'hE1,0,0,0,0,1,2);
    step(1,0,8'hE2,0,0,0,0,1,3);
    step(0,1,0,0,0,0,0,1,4);
    step(0,0,0,1,7'h33,0,0,1,5);
    idle(); idle();
    load(7'h10); rd_code(); rd_code(); idle();
    // R6: collided read completes later
    load(7'h20);
    step(0,1,0,0,0,0,0,1,1);
    step(0,0,0,0,0,0,0,1,2);
    idle(); idle();
    // R10: write and read together -> write only
    load(7'h40);
    step(1,1,8'h9C,0,0,0,0,0,0); idle(); idle();
    load(7'h40); rd_code(); idle();
    // R9: alternate writes and refreshes
    load(7'h00);
    for (int i = 0; i < 16; i++) begin
      wr_code(8'(8'hC0 + i));
      refresh_all();
    end
    // R5: reset in mid-run clears the offset
    shift(1, 0); shift(1, 0);
    idle(); idle();
    do_reset();
    refresh_all();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 20, (r >= 20 && r < 35), 8'($urandom), (r >= 35 && r < 40), 7'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 2) != 0, 3'($urandom));
    end
    repeat (4) idle();
    check(ref_q.size() == 0, "R3 missing refresh results", ref_q.size(), 0);
    check(rd_q.size() == 0, "R8 missing read results", rd_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule